// File: doc/BRIEF.md
# Redundant Four-State Countdown Counter

This block is a countdown counter built from a row of identical cells. Each cell holds one of four symbolic states (Zero, One, Two, Done) on two state wires. A transfer stage sits between every pair of neighbouring cells. The most significant cell is on the left, and beyond it sits a fixed cap that always looks like a Done cell. On every clock edge each stage looks at its two neighbours and may fire, which moves value one position toward the least significant cell. A Done marker creeps in from the cap behind the remaining value and signals that the count is used up.

A requester at the LSB end raises `dec_req` and holds it. The block answers with a one-cycle `dec_ack`, and `dec_ok` tells whether the decrement succeeded. If the LSB cell is still empty, the request waits until a stage firing fills it. A synchronous parallel load writes One into every cell whose load bit is set and Zero into all other cells. A synchronous clear empties the whole row.

Top module: `relay_dec_counter`

## Requirements
- R1: Synchronous active-high `rst` and `clr` force every cell to Zero at the edge where they are sampled, and `dec_ack` reads 0. Clear takes priority over load.
- R2: `load` sets cell k to One when `load_val[k]` is 1 and to Zero when it is 0. The result is visible right after that edge.
- R3: Cell k appears on `state_hi[k]` (Done or Two) and `state_lo[k]` (One or Two). Zero = hi 0 / lo 0, One = 0/1, Two = 1/1, Done = 1/0.
- R4: A stage fires only when its left cell is non-Zero and its right cell is Zero. A left Two becomes One, and the right cell becomes Two.
- R5: When a firing stage has One on its left, the left cell becomes Zero and the right cell becomes Two.
- R6: When a firing stage has Done on its left, both cells end up Done. The cap beyond cell N-1 acts as a permanent Done cell, so Done enters the row at the MSB and moves one cell per cycle.
- R7: A request accepted while the LSB is One or Two sets the LSB to Zero. `dec_ack` is high for exactly one cycle, with `dec_ok`=1, in the cycle after acceptance.
- R8: A request accepted while the LSB is Done also empties the LSB, and it answers `dec_ok`=0.
- R9: While the LSB is Zero, a held request is not accepted and `dec_ack` stays 0.
- R10: After a load of value v with no further load or clear, the number of successful decrements before the first failure is v[0] + sum over j>=1 of v[j]*2^(j-1).
- R11: A Done cell always has only Done cells to its left.
- R12: Load and clear block acceptance of a decrement in the same cycle and override any stage firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all cells to Zero |
| load | input | 1 | Synchronous parallel load strobe |
| load_val | input | N_CELLS | One bit per cell: 1 loads One, 0 loads Zero |
| dec_req | input | 1 | Decrement request, held until acknowledged |
| dec_ack | output | 1 | One-cycle acknowledge of a decrement |
| dec_ok | output | 1 | With `dec_ack`: 1 success, 0 exhausted |
| state_hi | output | N_CELLS | Per-cell wire, high for Done or Two |
| state_lo | output | N_CELLS | Per-cell wire, high for One or Two |

## Verification
A single MSB bit is loaded and the wires are traced cycle by cycle. This separates the Two-giving rule, the One-giving rule and the cap injecting Done, and it also shows a request stalled on an empty LSB. Loading all zeros shows the Done marker walking down and the failure answer. A clear or a load issued together with a request shows their priority. Random load values, each drained until the first failure, compare the success count with the weighted formula, which every firing rule affects. A monitor checks throughout that Done stays contiguous from the MSB.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  // bit 1: Done-or-Two wire, bit 0: One-or-Two wire
  typedef logic [1:0] cell_t;
  localparam cell_t C_ZERO = 2'b00;
  localparam cell_t C_ONE  = 2'b01;
  localparam cell_t C_TWO  = 2'b11;
  localparam cell_t C_DONE = 2'b10;
endpackage

// File: rtl/rdc_stage.sv
module rdc_stage
  import rdc_pkg::*;
(
  input  cell_t left_st,
  input  cell_t right_st,
  output logic  fire,
  output cell_t fill
);
  always_comb begin
    fire = (left_st != C_ZERO) && (right_st == C_ZERO);
    // One or Two on the left hands over a Two; Done hands over Done
    fill = (left_st == C_DONE) ? C_DONE : C_TWO;
  end
endmodule

// File: rtl/rdc_cell.sv
module rdc_cell
  import rdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  load,
  input  logic  load_bit,
  input  logic  recv,
  input  cell_t recv_val,
  input  logic  give,
  input  logic  drain,
  output cell_t st
);
  cell_t give_val;

  always_comb begin
    case (st)
      C_TWO:   give_val = C_ONE;
      C_ONE:   give_val = C_ZERO;
      default: give_val = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  st <= C_ZERO;
    else if (load)   st <= {1'b0, load_bit};
    else if (recv)   st <= recv_val;
    else if (give)   st <= give_val;
    else if (drain)  st <= C_ZERO;
  end

  AST_FILL_KIND: assert property (@(posedge clk) disable iff (rst)
    (st == C_ZERO && !clr && !load) |=> (st == C_ZERO || st[1])); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st == C_DONE && !clr && !load && !drain) |=> (st == C_DONE)); // R6
endmodule

// File: rtl/rdc_dec_port.sv
module rdc_dec_port
  import rdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  load,
  input  logic  req,
  input  cell_t lsb,
  output logic  drain,
  output logic  ack,
  output logic  ok
);
  always_comb drain = req && !ack && (lsb != C_ZERO) && !clr && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      ok  <= 1'b0;
    end else begin
      ack <= drain;
      ok  <= drain && lsb[0];
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R7
  AST_OK_FROM_VALUE: assert property (@(posedge clk) disable iff (rst)
    (ack && ok) |-> $past(lsb == C_ONE || lsb == C_TWO)); // R7
  AST_FAIL_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
    (ack && !ok) |-> $past(lsb == C_DONE)); // R8
  AST_NO_ACK_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(lsb != C_ZERO)); // R9
  AST_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    ack |-> !$past(clr || load)); // R12
endmodule

// File: rtl/relay_dec_counter.sv
module relay_dec_counter
  import rdc_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               load,
  input  logic [N_CELLS-1:0] load_val,
  input  logic               dec_req,
  output logic               dec_ack,
  output logic               dec_ok,
  output logic [N_CELLS-1:0] state_hi,
  output logic [N_CELLS-1:0] state_lo
);
  localparam int MSB = N_CELLS - 1;

  cell_t              st   [N_CELLS];
  cell_t              fill [N_CELLS];
  logic [N_CELLS-1:0] fire;
  logic               drain;

  // stage k feeds cell k from its left neighbour (the cap for the MSB)
  for (genvar k = 0; k < N_CELLS; k++) begin : g_row
    cell_t left_st;
    logic  give_k;
    logic  drain_k;
    if (k == MSB) begin : g_cap
      assign left_st = C_DONE;
    end else begin : g_mid
      assign left_st = st[k+1];
    end
    if (k == 0) begin : g_lsb
      assign give_k  = 1'b0;
      assign drain_k = drain;
    end else begin : g_upper
      assign give_k  = fire[k-1];
      assign drain_k = 1'b0;
    end

    rdc_stage u_stage (
      .left_st  (left_st),
      .right_st (st[k]),
      .fire     (fire[k]),
      .fill     (fill[k])
    );

    rdc_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .load     (load),
      .load_bit (load_val[k]),
      .recv     (fire[k]),
      .recv_val (fill[k]),
      .give     (give_k),
      .drain    (drain_k),
      .st       (st[k])
    );

    assign state_hi[k] = st[k][1];
    assign state_lo[k] = st[k][0];

    if (k < MSB) begin : g_contig
      AST_DONE_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (st[k] == C_DONE) |-> (st[k+1] == C_DONE)); // R11
    end
  end

  rdc_dec_port u_port (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .load  (load),
    .req   (dec_req),
    .lsb   (st[0]),
    .drain (drain),
    .ack   (dec_ack),
    .ok    (dec_ok)
  );

  AST_LSB_CLEARED: assert property (@(posedge clk) disable iff (rst)
    dec_ack |-> (st[0] == C_ZERO)); // R7
endmodule

// File: tb/relay_dec_counter_bench.sv
module relay_dec_counter_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr = 1'b0;
  logic         load = 1'b0;
  logic [N-1:0] load_val = '0;
  logic         dec_req = 1'b0;
  logic         dec_ack;
  logic         dec_ok;
  logic [N-1:0] state_hi;
  logic [N-1:0] state_lo;

  int n_cmp = 0;
  int n_bad = 0;
  int n_viol = 0;

  always #2 clk = ~clk; // 250 MHz

  relay_dec_counter #(.N_CELLS(N)) u_relay_dec_counter (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .load_val(load_val),
    .dec_req(dec_req), .dec_ack(dec_ack), .dec_ok(dec_ok),
    .state_hi(state_hi), .state_lo(state_lo)
  );

  function automatic int exp_count(logic [N-1:0] v);
    int c = int'(v[0]);
    for (int j = 1; j < N; j++) if (v[j]) c += 1 << (j - 1);
    return c;
  endfunction

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_load(input logic [N-1:0] v);
    load_val = v; load = 1'b1;
    step();
    load = 1'b0;
  endtask

  task automatic chk_state(input string tag, input logic [N-1:0] hi, input logic [N-1:0] lo);
    chk(state_hi == hi, {tag, " hi"}, int'(state_hi), int'(hi));
    chk(state_lo == lo, {tag, " lo"}, int'(state_lo), int'(lo));
  endtask

  task automatic decrement(output bit ok, output bit got);
    got = 1'b0; ok = 1'b0;
    dec_req = 1'b1;
    for (int i = 0; i < 100 && !got; i++) begin
      step();
      if (dec_ack) begin ok = dec_ok; got = 1'b1; end
    end
    dec_req = 1'b0;
  endtask

  task automatic count_run(input logic [N-1:0] v);
    int cnt = 0;
    bit ok, got, done;
    done = 1'b0;
    do_load(v);
    for (int i = 0; i < 400 && !done; i++) begin
      decrement(ok, got);
      if (!got) begin
        chk(1'b0, "R9 request never acknowledged", 0, 1);
        done = 1'b1;
      end else if (ok) cnt++;
      else done = 1'b1;
    end
    chk(cnt == exp_count(v), "R10 success count", cnt, exp_count(v));
  endtask

  // R11: Done may only have Done to its left
  always @(negedge clk) begin
    if (!rst)
      for (int k = 0; k < N - 1; k++)
        if (state_hi[k] && !state_lo[k] && !(state_hi[k+1] && !state_lo[k+1]))
          n_viol++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit ok, got;
    void'($urandom(32'd4242));
    repeat (4) step();
    // R1: reset state
    chk_state("R1 reset", '0, '0);
    chk(dec_ack == 1'b0, "R1 ack in reset", int'(dec_ack), 0);
    rst = 1'b0;
    repeat (3) step();
    // R1: clear beats load
    clr = 1'b1; load = 1'b1; load_val = '1;
    step();
    clr = 1'b0; load = 1'b0;
    chk_state("R1 clear", '0, '0);

    // R2/R3: load pattern, One = hi0 lo1
    do_load(8'b1010_0110);
    chk_state("R2 R3 load", '0, 8'b1010_0110);

    // R4/R5/R6/R9: single MSB bit traced with held request
    load_val = 8'h80; load = 1'b1; dec_req = 1'b1;
    step();
    load = 1'b0;
    chk(dec_ack == 1'b0, "R12 no ack at load", int'(dec_ack), 0);
    step();
    chk_state("R5 One gives Two", 8'b0100_0000, 8'b0100_0000);
    chk(dec_ack == 1'b0, "R9 stall t1", int'(dec_ack), 0);
    step();
    chk_state("R4 R6 Two splits, cap injects Done", 8'b1010_0000, 8'b0110_0000);
    step();
    chk_state("R4 second split", 8'b1001_0000, 8'b0111_0000);
    for (int t = 4; t <= 7; t++) begin
      step();
      chk(dec_ack == 1'b0, "R9 stall while LSB Zero", int'(dec_ack), 0);
    end
    step();
    chk(dec_ack && dec_ok, "R7 ack ok after LSB filled", int'({dec_ack, dec_ok}), 3);
    chk(!state_hi[0] && !state_lo[0], "R7 LSB drained", int'({state_hi[0], state_lo[0]}), 0);
    dec_req = 1'b0;
    step();
    chk(dec_ack == 1'b0, "R7 ack one cycle", int'(dec_ack), 0);

    // R6/R8: empty load, Done walks down, decrement fails
    do_load('0);
    step();
    chk_state("R6 Done enters MSB", 8'h80, 8'h00);
    repeat (2) step();
    chk_state("R6 Done moves one per cycle", 8'hE0, 8'h00);
    repeat (5) step();
    chk_state("R6 Done fills row", 8'hFF, 8'h00);
    decrement(ok, got);
    chk(got && !ok, "R8 fail on Done", int'({got, ok}), 2);

    // R12: clear with request pending, then load with request pending
    do_load(8'h01);
    clr = 1'b1; dec_req = 1'b1;
    step();
    clr = 1'b0; dec_req = 1'b0;
    chk(dec_ack == 1'b0, "R12 clear blocks ack", int'(dec_ack), 0);
    chk_state("R12 clear overrides", '0, '0);
    load_val = 8'h01; load = 1'b1; dec_req = 1'b1;
    step();
    load = 1'b0;
    chk(dec_ack == 1'b0, "R12 load blocks ack", int'(dec_ack), 0);
    chk(state_lo[0] == 1'b1, "R12 load value kept", int'(state_lo[0]), 1);
    step();
    chk(dec_ack && dec_ok, "R7 ack after load", int'({dec_ack, dec_ok}), 3);
    dec_req = 1'b0;
    step();

    // R10: directed corners and random loads
    count_run('0);
    count_run(8'h01);
    count_run('1);
    count_run(8'h80);
    for (int i = 0; i < 12; i++) count_run(N'($urandom));

    chk(n_viol == 0, "R11 Done contiguous", n_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule